// File: doc/BRIEF.md
# Error-Tolerant Frame Sync Detector

This block searches a serial bit stream for a fixed marker word that a transmitter places at the head of every frame. Each accepted bit enters a sliding window of the last N bits. The window is compared position by position with the marker. The number of differing positions is the error count for that alignment. When the count is no greater than a threshold set at run time, the block reports a hit, so a marker with a few corrupted bits is still found.

The mismatch count comes from a balanced tree of pairwise adders. The tree has a register stage after every second level and after its last level, so the logic between flops stays shallow even for wide markers. A comparison stage follows the tree, and the hit flag and the error count leave the block together.

The input is a valid-only stream: the detector accepts every bit whose `bit_valid` is high and has no ready signal, so there is no back-pressure. A new alignment can be evaluated every cycle.

Top module: `sync_hunt_det`

## Requirements
- R1: A synchronous active-high reset clears the window, the accepted-bit count and every pipeline stage. While reset is held and on the cycle after it, `sync_hit` is 0 and `err_count` is 0.
- R2: Each bit with `bit_valid` high enters window bit 0 as the older bits move up one place. Window bit i is compared with `PATTERN[i]`, so the marker is sent most significant bit first. The error count is the number of ones in window XOR `PATTERN`.
- R3: `sync_hit` is high for exactly one cycle for each evaluated alignment whose error count is less than or equal to `err_limit`. With `err_limit` = 0, only an exact match gives a hit.
- R4: No alignment is evaluated until N bits have been accepted since reset. The N-th accepted bit gives the first evaluation.
- R5: A cycle with `bit_valid` low leaves the window unchanged, whatever `bit_in` is. It also evaluates nothing and gives no hit.
- R6: `err_count` covers the full range 0 to N. A window that is the bitwise inverse of the marker reports N, and it gives a hit when `err_limit` = N.
- R7: The result for the bit accepted at clock edge e appears after edge e + ceil(clog2(N)/2) + 1, which is edge e + 4 for N = 32. `err_count` keeps the last evaluated count until the next evaluation.
- R8: Accepted bits on consecutive cycles give one evaluation per cycle, with no gaps.
- R9: A reset in the middle of a stream restarts the N-bit fill requirement of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | High when `bit_in` carries a bit; the bit is always accepted |
| err_limit | input | clog2(N+1) | Highest error count that still counts as a hit |
| sync_hit | output | 1 | One-cycle pulse for an alignment that meets the limit |
| err_count | output | clog2(N+1) | Error count of the most recently evaluated alignment |

## Verification
The bench builds the detector with N = 32 and a non-symmetric 32-bit marker. This gives a five-level tree, where the last level is registered on its own, and a 6-bit threshold that can reach N itself. With these values the bench covers the exact-fill boundary, the limit and limit+1 boundary with flipped bits at random positions, the all-inverted window at the top of the count range, and streams with gaps. A bench-side reference window predicts every output cycle from the stated latency.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  // adder-tree depth for an N-input ones count (at least one level)
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // number of register stages inside the tree
  function automatic int tree_stages(input int n);
    int l;
    l = tree_levels(n);
    return (l + 1) / 2;
  endfunction

  // a level is registered every second level and at the root
  function automatic bit level_is_reg(input int lvl, input int last);
    return ((lvl % 2) == 0) || (lvl == last);
  endfunction

  // bit offset of level lvl in the flat tree bus; level k holds
  // (m >> k) nodes, each k+1 bits wide
  function automatic int level_off(input int lvl, input int m);
    int acc;
    acc = 0;
    for (int k = 0; k < lvl; k++) acc += (m >> k) * (k + 1);
    return acc;
  endfunction

endpackage

// File: rtl/sync_bit_window.sv
module sync_bit_window #(
  parameter int N  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  input  logic         bit_valid,
  output logic [N-1:0] win,
  output logic         win_v
);

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      win   <= '0;
      seen  <= '0;
      win_v <= 1'b0;
    end else begin
      // the window is full once this bit lands
      win_v <= bit_valid && (seen >= CW'(N - 1));
      if (bit_valid) begin
        win <= {win[N-2:0], bit_in};
        if (seen != CW'(N)) seen <= seen + 1'b1;
      end
    end
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> (win[0] == $past(bit_in)));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(win) && !win_v));

  assert_full_before_eval_R4: assert property (@(posedge clk) disable iff (rst)
    win_v |-> (seen == CW'(N)));

endmodule

// File: rtl/sync_sum_level.sv
module sync_sum_level #(
  parameter int IN_N = 2,
  parameter int IW   = 1,
  parameter bit REG  = 1'b1,
  localparam int OUT_N = IN_N / 2,
  localparam int OW    = IW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IN_N*IW-1:0]    din,
  input  logic                  din_v,
  output logic [OUT_N*OW-1:0]   dout,
  output logic                  dout_v
);

  logic [OUT_N*OW-1:0] sums;

  always_comb begin
    for (int j = 0; j < OUT_N; j++) begin
      sums[j*OW +: OW] = OW'(din[(2*j)*IW +: IW]) + OW'(din[(2*j+1)*IW +: IW]);
    end
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        dout   <= '0;
        dout_v <= 1'b0;
      end else begin
        dout   <= sums;
        dout_v <= din_v;
      end
    end

    assert_valid_flow_R8: assert property (@(posedge clk) disable iff (rst)
      din_v |=> dout_v);
  end else begin : g_comb
    always_comb begin
      dout   = sums;
      dout_v = din_v;
    end
  end

endmodule

// File: rtl/sync_ones_tree.sv
module sync_ones_tree
  import sync_hunt_pkg::*;
#(
  parameter int N  = 32,
  parameter int OW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  bits,
  input  logic          in_v,
  output logic [OW-1:0] sum,
  output logic          sum_v
);

  localparam int L   = tree_levels(N);
  localparam int M   = 1 << L;
  localparam int TOT = level_off(L + 1, M);

  wire [TOT-1:0] bus;
  wire [L:0]     vbus;

  // level 0: one-bit leaves, padded with zeros up to a power of two
  assign bus[M-1:0] = M'(bits);
  assign vbus[0]    = in_v;

  for (genvar l = 1; l <= L; l++) begin : g_lvl
    sync_sum_level #(
      .IN_N (M >> (l - 1)),
      .IW   (l),
      .REG  (level_is_reg(l, L))
    ) u_level (
      .clk    (clk),
      .rst    (rst),
      .din    (bus[level_off(l - 1, M) +: (M >> (l - 1)) * l]),
      .din_v  (vbus[l - 1]),
      .dout   (bus[level_off(l, M) +: (M >> l) * (l + 1)]),
      .dout_v (vbus[l])
    );
  end

  assign sum   = OW'(bus[level_off(L, M) +: L + 1]);
  assign sum_v = vbus[L];

  assert_sum_range_R6: assert property (@(posedge clk) disable iff (rst)
    sum_v |-> (sum <= OW'(N)));

endmodule

// File: rtl/sync_hunt_det.sv
module sync_hunt_det #(
  parameter int N = 32,
  parameter logic [N-1:0] PATTERN = N'(32'hE5A3_C96B),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_in,
  input  logic          bit_valid,
  input  logic [CW-1:0] err_limit,
  output logic          sync_hit,
  output logic [CW-1:0] err_count
);

  logic [N-1:0]  win;
  logic          win_v;
  logic [CW-1:0] tree_sum;
  logic          tree_v;

  sync_bit_window #(.N(N), .CW(CW)) u_window (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .win       (win),
    .win_v     (win_v)
  );

  sync_ones_tree #(.N(N), .OW(CW)) u_tree (
    .clk   (clk),
    .rst   (rst),
    .bits  (win ^ PATTERN),
    .in_v  (win_v),
    .sum   (tree_sum),
    .sum_v (tree_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_hit  <= 1'b0;
      err_count <= '0;
    end else begin
      sync_hit <= tree_v && (tree_sum <= err_limit);
      if (tree_v) err_count <= tree_sum;
    end
  end

  assert_hit_within_limit_R3: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> (err_count <= $past(err_limit)));

  assert_hit_from_eval_R7: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> $past(tree_v));

  assert_count_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !tree_v |=> $stable(err_count));

endmodule

// File: tb/sync_hunt_det_test.sv
module sync_hunt_det_test;

  localparam int N   = 32;
  localparam int CW  = $clog2(N + 1);
  localparam logic [N-1:0] PAT = 32'hE5A3_C96B;
  localparam int LAT = ($clog2(N) + 1) / 2 + 1;  // R7: 4 for N = 32

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_in = 1'b0;
  logic          bit_valid = 1'b0;
  logic [CW-1:0] err_limit = '0;
  logic          sync_hit;
  logic [CW-1:0] err_count;

  sync_hunt_det #(.N(N), .PATTERN(PAT)) uut (
    .clk (clk), .rst (rst), .bit_in (bit_in), .bit_valid (bit_valid),
    .err_limit (err_limit), .sync_hit (sync_hit), .err_count (err_count)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [N-1:0] m_win = '0;
  int m_seen = 0;
  bit r_ev [8];
  bit r_hit [8];
  int r_err [8];
  int hold_err = 0;
  int obs_evals = 0;
  int obs_hits = 0;
  bit obs_last_hit = 1'b0;
  string cur_tag = "R1";

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic b, input logic v);
    int s;
    bit_in = b;
    bit_valid = v;
    @(posedge clk);
    cyc++;
    if (v) begin
      m_win = {m_win[N-2:0], b};
      if (m_seen < N) m_seen++;
      if (m_seen >= N) begin
        s = (cyc + LAT) % 8;
        r_ev[s]  = 1'b1;
        r_err[s] = $countones(m_win ^ PAT);
        r_hit[s] = (r_err[s] <= int'(err_limit));
      end
    end
    @(negedge clk);
    s = cyc % 8;
    if (r_ev[s]) begin
      hold_err = r_err[s];
      obs_evals++;
      obs_last_hit = sync_hit;
    end
    if (sync_hit) obs_hits++;
    check({cur_tag, " sync_hit"}, int'(sync_hit), int'(r_ev[s] && r_hit[s]));
    check({cur_tag, " err_count"}, int'(err_count), hold_err);
    r_ev[s] = 1'b0;
    r_hit[s] = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'($urandom_range(1)), 1'b0);
  endtask

  task automatic send_word(input logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) step(w[i], 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    repeat (2) @(posedge clk);
    cyc += 2;
    @(negedge clk);
    check("R1 sync_hit in reset", int'(sync_hit), 0);
    check("R1 err_count in reset", int'(err_count), 0);
    rst = 1'b0;
    m_win = '0;
    m_seen = 0;
    hold_err = 0;
    for (int i = 0; i < 8; i++) begin
      r_ev[i] = 1'b0;
      r_hit[i] = 1'b0;
      r_err[i] = 0;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check("R1 sync_hit after reset", int'(sync_hit), 0);
    check("R1 err_count after reset", int'(err_count), 0);
  endtask

  function automatic logic [N-1:0] flip_mask(input int nerr);
    logic [N-1:0] m;
    m = '0;
    while ($countones(m) < nerr) m[$urandom_range(N - 1)] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    cur_tag = "R1";
    do_reset();
  endtask

  task automatic t_fill_boundary();
    int ev0;
    cur_tag = "R4";
    err_limit = '0;
    do_reset();
    ev0 = obs_evals;
    for (int i = N - 1; i >= 1; i--) step(PAT[i], 1'b1);
    idle(LAT + 2);
    check("R4 no eval before N bits", obs_evals - ev0, 0);
    step(PAT[0], 1'b1);
    idle(LAT + 1);
    check("R4 first eval on Nth bit", obs_evals - ev0, 1);
    check("R2 exact marker hit", int'(obs_last_hit), 1);
    check("R2 exact marker count", int'(err_count), 0);
  endtask

  task automatic t_zero_limit();
    cur_tag = "R3";
    err_limit = '0;
    send_word(PAT ^ flip_mask(1));
    idle(LAT + 1);
    check("R3 limit 0 one error no hit", int'(obs_last_hit), 0);
    check("R3 limit 0 one error count", int'(err_count), 1);
    send_word(PAT);
    idle(LAT + 1);
    check("R3 limit 0 exact hit", int'(obs_last_hit), 1);
  endtask

  task automatic t_threshold();
    cur_tag = "R3";
    err_limit = CW'(3);
    for (int rep = 0; rep < 3; rep++) begin
      for (int nerr = 0; nerr <= 4; nerr++) begin
        send_word(PAT ^ flip_mask(nerr));
        idle(LAT + 1);
        check("R3 threshold count", int'(err_count), nerr);
        check("R3 threshold decision", int'(obs_last_hit), int'(nerr <= 3));
      end
    end
  endtask

  task automatic t_gaps();
    int ev0;
    cur_tag = "R5";
    err_limit = CW'(2);
    do_reset();
    ev0 = obs_evals;
    for (int i = N - 1; i >= 0; i--) begin
      step(PAT[i], 1'b1);
      idle(1 + (i % 3));
    end
    idle(LAT + 1);
    check("R5 gaps give one eval", obs_evals - ev0, 1);
    check("R5 gaps leave window intact", int'(err_count), 0);
    check("R5 gaps hit", int'(obs_last_hit), 1);
  endtask

  task automatic t_full_range();
    cur_tag = "R6";
    err_limit = CW'(N);
    send_word(~PAT);
    idle(LAT + 1);
    check("R6 inverse count", int'(err_count), N);
    check("R6 inverse hit at limit N", int'(obs_last_hit), 1);
    err_limit = CW'(N - 1);
    send_word(~PAT);
    idle(LAT + 1);
    check("R6 inverse no hit at N-1", int'(obs_last_hit), 0);
  endtask

  task automatic t_burst();
    int h0;
    cur_tag = "R8";
    err_limit = CW'(N);
    h0 = obs_hits;
    for (int i = 0; i < 10; i++) step(1'($urandom_range(1)), 1'b1);
    idle(LAT + 1);
    check("R8 one hit per bit", obs_hits - h0, 10);
  endtask

  task automatic t_mid_reset();
    int ev0;
    cur_tag = "R9";
    err_limit = CW'(N);
    for (int i = 0; i < N / 2; i++) step(1'($urandom_range(1)), 1'b1);
    do_reset();
    ev0 = obs_evals;
    for (int i = 0; i < N - 1; i++) step(1'($urandom_range(1)), 1'b1);
    idle(LAT + 1);
    check("R9 refill needed after reset", obs_evals - ev0, 0);
    step(1'b1, 1'b1);
    idle(LAT + 1);
    check("R9 eval after refill", obs_evals - ev0, 1);
  endtask

  task automatic t_random();
    cur_tag = "R7";
    err_limit = CW'(4);
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 20; i++) step(1'($urandom_range(1)), 1'($urandom_range(3) != 0));
      send_word(PAT ^ flip_mask($urandom_range(5)));
    end
    idle(LAT + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_boundary();
    t_zero_limit();
    t_threshold();
    t_gaps();
    t_full_range();
    t_burst();
    t_mid_reset();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule